// File: doc/BRIEF.md
# Dual-Compare Free-Running Interval Timer

This block holds one 16-bit up-counter that runs freely while enabled and rolls over from all ones to zero. Two compare channels watch it. Each channel has its own compare register, interrupt pulse and toggling output pin. A match never resets the counter, so the two channels keep independent schedules on the same count.

The host sets a periodic interval on a channel by writing a first compare value before enabling. After each interrupt it writes the old compare value plus the wanted period, truncated to 16 bits. The gap between consecutive matches is then the difference of the two compare values modulo 2^16. This holds even when the new value lies past the counter rollover. An overflow pulse marks each rollover.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset all outputs are low, the counter is zero and both compare registers hold zero.
- R2: While `cnt_en` is high the counter advances by one per clock, modulo 2^16, and a match never clears it. The first match of a channel whose compare value D was loaded before enabling shows as an interrupt after exactly D+1 enabled clocks.
- R3: `ovf` is high for exactly one clock, the clock after the counter held 16'hFFFF with `cnt_en` high.
- R4: `irq[i]` is high for exactly one clock, the clock after one in which `cnt_en` was high and the counter equalled compare register i. It is low at every other time. The two channels act independently.
- R5: When the host writes compare value old+P (mod 2^16) to a channel after its interrupt, with P at least 4, the next interrupt of that channel comes exactly P clocks after the previous one. This also holds when the sum wraps past 16'hFFFF.
- R6: `tout[i]` inverts in the same clock that `irq[i]` rises. While `cnt_en` stays high it does not change otherwise.
- R7: A clock sampled with `cnt_en` low returns the counter to zero and drives both `tout` pins low from the next clock. No interrupt or overflow results from it.
- R8: A write (`wr_en` high, `wr_sel` = channel index 0 or 1, `wr_data` = value) takes effect for comparison from the next clock. A value equal to the current count gives no match until the counter reaches it again, and a value one above the current count matches on the next clock.
- R9: Compare registers change only through writes addressed to them. They keep their contents while `cnt_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable; low holds the counter at zero |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 1 | Channel index of the write |
| wr_data | input | 16 | Compare value to write |
| irq | output | 2 | One-clock interrupt pulse per channel |
| tout | output | 2 | Timer output pin per channel, toggled on match |
| ovf | output | 1 | One-clock pulse on counter rollover |

## Verification
Directed patterns come first. Loading 5 and 9 before enabling tells a correct D+1 first-match latency apart from an off-by-one start. A compare write equal to the live count, and another one count above it, tell next-clock write timing from same-clock timing. A disable/re-enable cycle around a retained compare value shows whether the counter restarts at zero and the register survives. A long run then has the host re-arming both channels with random periods past 65536 counts, which separates true modulo interval arithmetic from a counter that clears or saturates at rollover. A random mix of enable drops and writes near the live count follows, and a cycle model checks it every clock.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int unsigned DCT_CNT_W  = 16;
  localparam int unsigned DCT_NUM_CH = 2;

  // Width of the channel select field for a given channel count.
  function automatic int unsigned dct_sel_w(input int unsigned n_ch);
    return (n_ch > 1) ? $clog2(n_ch) : 1;
  endfunction

endpackage

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int unsigned CNT_W = dct_pkg::DCT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_evt,
  output logic             ovf_q
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] f_next(input logic [CNT_W-1:0] v,
                                              input logic en);
    return en ? (v + {{(CNT_W-1){1'b0}}, 1'b1}) : '0;
  endfunction

  function automatic logic f_wrap(input logic [CNT_W-1:0] v, input logic en);
    return en && (v == CNT_TOP);
  endfunction

  assign wrap_evt = f_wrap(cnt_q, run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= f_next(cnt_q, run);
      ovf_q <= wrap_evt;
    end
  end

endmodule

// File: rtl/dct_cmp_bank.sv
module dct_cmp_bank #(
  parameter int unsigned CNT_W  = dct_pkg::DCT_CNT_W,
  parameter int unsigned NUM_CH = dct_pkg::DCT_NUM_CH,
  parameter int unsigned SEL_W  = dct_pkg::dct_sel_w(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [CNT_W-1:0]        wr_data,
  output logic [NUM_CH*CNT_W-1:0] cmp_flat
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
    logic             wr_hit;
    logic [CNT_W-1:0] cmp_q;

    assign wr_hit = wr_en && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (wr_hit) cmp_q <= wr_data;
    end

    assign cmp_flat[g*CNT_W +: CNT_W] = cmp_q;
  end

endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
  parameter int unsigned CNT_W = dct_pkg::DCT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             hit,
  output logic             irq_q,
  output logic             tout_q
);

  function automatic logic f_hit(input logic en,
                                 input logic [CNT_W-1:0] c,
                                 input logic [CNT_W-1:0] r);
    return en && (c == r);
  endfunction

  function automatic logic f_pin(input logic en, input logic h, input logic cur);
    return en ? (cur ^ h) : 1'b0;
  endfunction

  assign hit = f_hit(run, cnt, cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      irq_q  <= hit;
      tout_q <= f_pin(run, hit, tout_q);
    end
  end

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int unsigned CNT_W  = dct_pkg::DCT_CNT_W,
  parameter int unsigned NUM_CH = dct_pkg::DCT_NUM_CH
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cnt_en,
  input  logic                                   wr_en,
  input  logic [dct_pkg::dct_sel_w(NUM_CH)-1:0]  wr_sel,
  input  logic [CNT_W-1:0]                       wr_data,
  output logic [NUM_CH-1:0]                      irq,
  output logic [NUM_CH-1:0]                      tout,
  output logic                                   ovf
);

  localparam int unsigned SEL_W = dct_pkg::dct_sel_w(NUM_CH);

  logic [CNT_W-1:0]        cnt_q;
  logic                    wrap_evt;
  logic [NUM_CH*CNT_W-1:0] cmp_flat;
  logic [NUM_CH-1:0]       hit_vec;

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cnt_en),
    .cnt_q    (cnt_q),
    .wrap_evt (wrap_evt),
    .ovf_q    (ovf)
  );

  dct_cmp_bank #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .cmp_flat (cmp_flat)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (cnt_en),
      .cnt    (cnt_q),
      .cmp    (cmp_flat[g*CNT_W +: CNT_W]),
      .hit    (hit_vec[g]),
      .irq_q  (irq[g]),
      .tout_q (tout[g])
    );
  end

endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned SEL_W  = 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cnt_en,
  input logic                    wr_en,
  input logic [SEL_W-1:0]        wr_sel,
  input logic [CNT_W-1:0]        wr_data,
  input logic [NUM_CH-1:0]       irq,
  input logic [NUM_CH-1:0]       tout,
  input logic                    ovf,
  input logic [CNT_W-1:0]        cnt_q,
  input logic                    wrap_evt,
  input logic [NUM_CH-1:0]       hit_vec,
  input logic [NUM_CH*CNT_W-1:0] cmp_flat
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> (cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, 1'b1})); // R2

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (cnt_q == '0)); // R7

  AST_OVF_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf); // R3

  AST_OVF_ONLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(wrap_evt)); // R3

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_IRQ_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[g] |=> irq[g]); // R4

    AST_IRQ_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> $past(hit_vec[g])); // R4

    AST_TOUT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[g] |=> (tout[g] != $past(tout[g]))); // R6

    AST_TOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !hit_vec[g]) |=> $stable(tout[g])); // R6

    AST_TOUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> !tout[g]); // R7

    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == SEL_W'(g))) |=>
        (cmp_flat[g*CNT_W +: CNT_W] == $past(wr_data))); // R8

    AST_CMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_sel == SEL_W'(g))) |=>
        $stable(cmp_flat[g*CNT_W +: CNT_W])); // R9
  end

endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(
  .CNT_W(CNT_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .irq      (irq),
  .tout     (tout),
  .ovf      (ovf),
  .cnt_q    (cnt_q),
  .wrap_evt (wrap_evt),
  .hit_vec  (hit_vec),
  .cmp_flat (cmp_flat)
);

// File: tb/dual_cmp_timer_tb.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb;
  localparam int W   = 16;
  localparam int NCH = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [0:0]    wr_sel = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [NCH-1:0] irq, tout;
  logic          ovf;

  always #10 clk = ~clk;

  dual_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq(irq), .tout(tout), .ovf(ovf)
  );

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  longint cyc = 0;

  // Port-level expectation built from the requirements.
  logic [W-1:0]   m_cnt = '0;
  logic [W-1:0]   m_cmp [NCH] = '{default: '0};
  logic [NCH-1:0] m_irq = '0, m_tout = '0;
  logic           m_ovf = 1'b0;

  function automatic logic [W-1:0] add_mod(input logic [W-1:0] a, input int unsigned b);
    logic [31:0] s;
    s = {16'd0, a} + b;
    return s[W-1:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    logic [NCH-1:0] n_irq, n_tout;
    logic           n_ovf;
    logic [W-1:0]   n_cnt;
    for (int c = 0; c < NCH; c++) begin
      n_irq[c]  = cnt_en && (m_cnt == m_cmp[c]);
      n_tout[c] = cnt_en ? (m_tout[c] ^ n_irq[c]) : 1'b0;
    end
    n_ovf = cnt_en && (m_cnt == {W{1'b1}});
    n_cnt = cnt_en ? add_mod(m_cnt, 1) : '0;
    @(posedge clk);
    if (wr_en) m_cmp[wr_sel] = wr_data;
    m_irq = n_irq; m_tout = n_tout; m_ovf = n_ovf; m_cnt = n_cnt;
    cyc++;
    @(negedge clk);
    wr_en = 1'b0;
    check("R4 irq", 32'(irq), 32'(m_irq));
    check("R6 tout", 32'(tout), 32'(m_tout));
    check("R3 ovf", 32'(ovf), 32'(m_ovf));
  endtask

  task automatic write_cmp(input int ch, input logic [W-1:0] v);
    wr_en = 1'b1; wr_sel = ch[0]; wr_data = v;
    step();
  endtask

  initial begin
    #(64'd20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int first0, first1, n_ovf_seen;
    bit any_irq1;
    longint last [NCH];
    int per [NCH];
    logic [W-1:0] sw_cmp [NCH];
    bit pend [NCH];

    void'($urandom(32'h1D2C3B4A));
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1 irq", 32'(irq), 0);
    check("R1 tout", 32'(tout), 0);
    check("R1 ovf", 32'(ovf), 0);
    rst_n = 1'b1;
    step();
    // R1: compare registers reset to zero -> both match at count 0
    cnt_en = 1'b1;
    step();
    check("R1 cmp zero", 32'(irq), 32'h3);
    cnt_en = 1'b0;
    step();

    // R2: first match D+1 clocks after enable
    write_cmp(0, 16'd5);
    write_cmp(1, 16'd9);
    cnt_en = 1'b1;
    first0 = 0; first1 = 0;
    for (int k = 1; k <= 20; k++) begin
      step();
      if (irq[0] && first0 == 0) first0 = k;
      if (irq[1] && first1 == 0) first1 = k;
    end
    check("R2 first match ch0", 32'(first0), 6);
    check("R2 first match ch1", 32'(first1), 10);

    // R8: write equal to live count gives no match for a long time
    write_cmp(1, m_cnt);
    any_irq1 = 1'b0;
    for (int k = 0; k < 300; k++) begin
      step();
      if (irq[1]) any_irq1 = 1'b1;
    end
    check("R8 equal-count write", 32'(any_irq1), 0);
    // R8: write one above live count matches on the next clock
    write_cmp(0, add_mod(m_cnt, 1));
    check("R8 next-count write (1)", 32'(irq[0]), 0);
    step();
    check("R8 next-count write (2)", 32'(irq[0]), 1);

    // R7 / R9: disable, retention of compare, restart from zero
    write_cmp(0, 16'd40);
    cnt_en = 1'b0;
    step();
    step();
    check("R7 tout low", 32'(tout), 0);
    repeat (5) step();
    cnt_en = 1'b1;
    first0 = 0;
    for (int k = 1; k <= 60; k++) begin
      step();
      if (irq[0] && first0 == 0) first0 = k;
    end
    check("R9 retained compare", 32'(first0), 41);

    // R5: host re-arming with random periods across the rollover
    cnt_en = 1'b0;
    step();
    for (int c = 0; c < NCH; c++) begin
      per[c] = 40 + int'($urandom % 860);
      sw_cmp[c] = W'(per[c] - 1);
      write_cmp(c, sw_cmp[c]);
      pend[c] = 1'b0;
    end
    cnt_en = 1'b1;
    for (int c = 0; c < NCH; c++) last[c] = cyc;
    n_ovf_seen = 0;
    for (int k = 0; k < 70000; k++) begin
      if (pend[0] || pend[1]) begin
        int c;
        c = pend[0] ? 0 : 1;
        pend[c] = 1'b0;
        per[c] = 40 + int'($urandom % 860);
        sw_cmp[c] = add_mod(sw_cmp[c], per[c]);
        write_cmp(c, sw_cmp[c]);
      end else begin
        step();
      end
      if (ovf) n_ovf_seen++;
      for (int c = 0; c < NCH; c++) begin
        if (irq[c]) begin
          check($sformatf("R5 interval ch%0d", c), 32'(cyc - last[c]), 32'(per[c]));
          last[c] = cyc;
          pend[c] = 1'b1;
        end
      end
    end
    check("R3 rollover count", 32'(n_ovf_seen), 1);

    // Random mix of enable drops and writes, checked by the model
    for (int k = 0; k < 3000; k++) begin
      cnt_en = ($urandom % 16) != 0;
      if ($urandom % 8 == 0) begin
        wr_en = 1'b1;
        wr_sel = 1'($urandom % 2);
        wr_data = ($urandom % 4 == 0) ? add_mod(m_cnt, $urandom % 3) : W'($urandom % 64);
      end
      step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule